// File: doc/BRIEF.md
# Interrupt Route Decoder with Selectable Field Encoding

This block takes a set of external interrupt request lines and steers each one to a single target CPU and a single interrupt pin on that CPU. Each source owns a 12-bit routing word. That word holds an 8-bit CPU field in bits 7:0 and a 4-bit pin field in bits 11:8. Software reaches the routing words, an enable mask, a pending mask, a configuration word and a read-only capability word through a simple synchronous register bus. Writes land on the clock edge. Reads are combinational on the address.

Two decoding styles exist for the routing fields. The compatible style treats each field as a bitmap. The CPU field is split into a node bitmap (bits 7:4) and a CPU-in-node bitmap (bits 3:0), and the pin field is also a bitmap. Under this style only four pins and four CPUs per node are reachable. The encoded style treats a field as a binary index, which reaches sixteen pins and up to 256 CPUs. The capability word says which encoded styles the build offers. The configuration word picks the style separately for the pin field and for the CPU field.

The output is a flat request vector with one bit per (CPU, pin) pair. It is registered, so it reflects the register and pending state of the previous cycle. A change in configuration re-interprets every stored routing word at once.

Top module: `irq_route_decoder`

## Requirements
- R1: After reset the configuration, enable and pending words read 0 and every output request bit is 0.
- R2: Address 0 is read-only capability: bit 0 is 1 when encoded pin selection is built in, bit 1 is 1 when encoded CPU selection is built in, and all other bits read 0.
- R3: Address 1 is configuration: bit 0 selects encoded pin decoding and bit 1 selects encoded CPU decoding. A written 1 is kept only where the matching capability bit is 1, and the word reads back as stored.
- R4: With configuration bit 1 clear, the target CPU is 4 × (lowest set bit of bits 7:4) + (lowest set bit of bits 3:0). If either nibble is zero, the source is delivered nowhere.
- R5: With configuration bit 0 clear, the target pin is the lowest set bit of bits 11:8. If that nibble is zero, the source is delivered nowhere.
- R6: With configuration bit 0 set, the target pin is the binary value of bits 11:8 (0 to 15). A pin at or above NUM_PIN is not delivered.
- R7: With configuration bit 1 set, the target CPU is the binary value of bits 7:0. A CPU at or above NUM_CPU is not delivered.
- R8: Output bit cpu × NUM_PIN + pin is the OR over all enabled, pending sources routed to that pair. It shows the state of the previous clock cycle.
- R9: A 0-to-1 edge on a request line sets that source's pending bit. A line held high does not set it again. Writing 1 to a bit of the pending word at address 3 clears it, and an edge in the same cycle wins over the clear.
- R10: Address 2 is the enable word. A pending source whose enable bit is 0 stays pending but drives no output.
- R11: A change of configuration re-decodes all stored routing words from the next cycle on, without rewriting them.
- R12: The routing word of source i sits at address 16 + i. It keeps bits 11:0 of the written data and reads back with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Interrupt request lines, edge sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_CPU*NUM_PIN | Registered request per (CPU, pin) pair |

## Verification
Several properties are checked on every cycle. Each source decodes to at most one (CPU, pin) pair. A request edge always leaves its pending bit set. A one-written clear removes a pending bit unless an edge arrives at the same time. With all enables off, the output is silent. Any active output bit must trace back to an enabled, pending source. The exact pair chosen under each decoding style needs the bench, and so do lowest-bit selection in overlapping bitmaps, dropping of targets that are out of range or have empty fields, re-decoding after a configuration change, and write masking on a build without the encoded styles. The bench's reference model predicts the whole output vector on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ROUTE_W    = 12;
    localparam int CPU_FLD_W  = 8;
    localparam int PIN_FLD_W  = 4;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 32;
    localparam int ROUTE_BASE = 16;

    localparam logic [ADDR_W-1:0] ADR_CAP  = 5'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG  = 5'd1;
    localparam logic [ADDR_W-1:0] ADR_EN   = 5'd2;
    localparam logic [ADDR_W-1:0] ADR_PEND = 5'd3;

    typedef struct packed {
        logic       valid;
        logic [1:0] idx;
    } low_bit_t;

    function automatic low_bit_t lowest_of4(input logic [3:0] v);
        low_bit_t r;
        r.valid = |v;
        if (v[0])      r.idx = 2'd0;
        else if (v[1]) r.idx = 2'd1;
        else if (v[2]) r.idx = 2'd2;
        else           r.idx = 2'd3;
        return r;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       cfg_pin_enc,
    output logic                       cfg_cpu_enc,
    output logic [NUM_SRC-1:0]         src_en,
    output logic [NUM_SRC-1:0]         src_pend,
    output logic [NUM_SRC*ROUTE_W-1:0] route_flat
);

    localparam logic [1:0] CAP_BITS = {HAS_CPU_ENC, HAS_PIN_ENC};

    logic [1:0]         cfg_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr;
    logic               wr_pend;
    logic [ROUTE_W-1:0] route_q [NUM_SRC];

    assign rise    = src_in & ~src_q;
    assign wr_pend = bus_wr && (bus_addr == ADR_PEND);
    assign clr     = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            src_q  <= '0;
        end else begin
            src_q  <= src_in;
            pend_q <= (pend_q & ~clr) | rise;
            if (bus_wr && bus_addr == ADR_CFG)
                cfg_q <= bus_wdata[1:0] & CAP_BITS;
            if (bus_wr && bus_addr == ADR_EN)
                en_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst)
                route_q[s] <= '0;
            else if (bus_wr && int'(bus_addr) == ROUTE_BASE + s)
                route_q[s] <= bus_wdata[ROUTE_W-1:0];
        end
        assign route_flat[s*ROUTE_W +: ROUTE_W] = route_q[s];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CAP:  bus_rdata[1:0]         = CAP_BITS;
            ADR_CFG:  bus_rdata[1:0]         = cfg_q;
            ADR_EN:   bus_rdata[NUM_SRC-1:0] = en_q;
            ADR_PEND: bus_rdata[NUM_SRC-1:0] = pend_q;
            default: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (int'(bus_addr) == ROUTE_BASE + s)
                        bus_rdata[ROUTE_W-1:0] = route_q[s];
            end
        endcase
    end

    assign cfg_pin_enc = cfg_q[0];
    assign cfg_cpu_enc = cfg_q[1];
    assign src_en      = en_q;
    assign src_pend    = pend_q;

    // R9: an edge on a request line leaves the pending bit set
    a_r9_edge_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R9: a one-written clear without a coincident edge empties the bit
    a_r9_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && ((clr & ~rise) != '0)) |=> ((pend_q & $past(clr & ~rise)) == '0));

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int NUM_PIN = 16
) (
    input  logic [ROUTE_W-1:0]         route,
    input  logic                       cfg_pin_enc,
    input  logic                       cfg_cpu_enc,
    output logic [NUM_CPU*NUM_PIN-1:0] hit
);

    low_bit_t             pin_low;
    low_bit_t             node_low;
    low_bit_t             core_low;
    logic [PIN_FLD_W-1:0] pin_idx;
    logic [CPU_FLD_W-1:0] cpu_idx;
    logic                 pin_ok;
    logic                 cpu_ok;

    always_comb begin
        pin_low  = lowest_of4(route[11:8]);
        node_low = lowest_of4(route[7:4]);
        core_low = lowest_of4(route[3:0]);

        if (cfg_pin_enc) begin
            pin_idx = route[11:8];
            pin_ok  = 1'b1;
        end else begin
            pin_idx = {2'b00, pin_low.idx};
            pin_ok  = pin_low.valid;
        end

        if (cfg_cpu_enc) begin
            cpu_idx = route[7:0];
            cpu_ok  = 1'b1;
        end else begin
            cpu_idx = {4'b0000, node_low.idx, core_low.idx};
            cpu_ok  = node_low.valid && core_low.valid;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++)
            for (int p = 0; p < NUM_PIN; p++)
                hit[c*NUM_PIN + p] = pin_ok && cpu_ok &&
                                     (int'(cpu_idx) == c) && (int'(pin_idx) == p);
    end

    // R4: any routing word names at most one destination
    always_comb begin
        a_r4_single_target: assert ($onehot0(hit));
    end

endmodule

// File: rtl/irq_route_decoder.sv
module irq_route_decoder
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int NUM_CPU     = 16,
    parameter int NUM_PIN     = 16,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       bus_wr,
    input  logic [4:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_CPU*NUM_PIN-1:0] irq_out
);

    localparam int OUT_W = NUM_CPU * NUM_PIN;

    logic                       cfg_pin_enc;
    logic                       cfg_cpu_enc;
    logic [NUM_SRC-1:0]         src_en;
    logic [NUM_SRC-1:0]         src_pend;
    logic [NUM_SRC*ROUTE_W-1:0] route_flat;
    logic [OUT_W-1:0]           hits [NUM_SRC];
    logic [OUT_W-1:0]           req_d;
    logic [OUT_W-1:0]           irq_q;

    irq_route_regs #(
        .NUM_SRC     (NUM_SRC),
        .HAS_PIN_ENC (HAS_PIN_ENC),
        .HAS_CPU_ENC (HAS_CPU_ENC)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .src_in      (src_in),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cfg_pin_enc (cfg_pin_enc),
        .cfg_cpu_enc (cfg_cpu_enc),
        .src_en      (src_en),
        .src_pend    (src_pend),
        .route_flat  (route_flat)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
        irq_route_decode #(
            .NUM_CPU (NUM_CPU),
            .NUM_PIN (NUM_PIN)
        ) u_dec (
            .route       (route_flat[s*ROUTE_W +: ROUTE_W]),
            .cfg_pin_enc (cfg_pin_enc),
            .cfg_cpu_enc (cfg_cpu_enc),
            .hit         (hits[s])
        );
    end

    always_comb begin
        req_d = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (src_en[s] && src_pend[s])
                req_d = req_d | hits[s];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= req_d;
    end

    assign irq_out = irq_q;

    // R10: with every source disabled the outputs fall silent next cycle
    a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (src_en == '0) |=> (irq_q == '0));

    // R8: an active request always stems from an enabled pending source
    a_r8_out_has_source: assert property (@(posedge clk) disable iff (rst)
        (irq_q != '0) |-> $past((src_en & src_pend) != '0));

endmodule

// File: tb/irq_route_decoder_test.sv
`timescale 1ns/1ps
module irq_route_decoder_test;

    localparam int NS = 8;
    localparam int NC = 16;
    localparam int NP = 16;
    localparam int OW = NC * NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   bare_rdata;
    logic [OW-1:0] irq_out;
    logic [OW-1:0] bare_irq;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_route_decoder #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_PIN(NP)) uut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out));

    irq_route_decoder #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_PIN(NP),
        .HAS_PIN_ENC(1'b0), .HAS_CPU_ENC(1'b0)) uut_bare (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bare_rdata), .irq_out(bare_irq));

    // behavioural reference model for uut
    int            m_cfg;
    bit [NS-1:0]   m_en, m_pend, m_srcq;
    int            m_route [NS];
    logic [OW-1:0] exp_out;

    function automatic int low_index(input int nib);
        for (int k = 0; k < 4; k++)
            if (nib[k]) return k;
        return -1;
    endfunction

    function automatic logic [OW-1:0] predict();
        logic [OW-1:0] v = '0;
        for (int s = 0; s < NS; s++) begin
            int pin, cpu, nd, cr;
            if (!(m_en[s] && m_pend[s])) continue;
            if (m_cfg[0]) pin = (m_route[s] >> 8) & 15;
            else          pin = low_index((m_route[s] >> 8) & 15);
            if (m_cfg[1]) cpu = m_route[s] & 255;
            else begin
                nd = low_index((m_route[s] >> 4) & 15);
                cr = low_index(m_route[s] & 15);
                cpu = (nd < 0 || cr < 0) ? -1 : nd * 4 + cr;
            end
            if (pin >= 0 && pin < NP && cpu >= 0 && cpu < NC)
                v[cpu*NP + pin] = 1'b1;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 0; m_en = '0; m_pend = '0; m_srcq = '0;
            for (int s = 0; s < NS; s++) m_route[s] = 0;
            exp_out = '0;
        end else begin
            bit [NS-1:0] clrv;
            exp_out = predict();
            clrv = (bus_wr && bus_addr == 5'd3) ? bus_wdata[NS-1:0] : '0;
            m_pend = (m_pend & ~clrv) | (src_in & ~m_srcq);
            m_srcq = src_in;
            if (bus_wr) begin
                if (bus_addr == 5'd1) m_cfg = int'(bus_wdata[1:0]);
                if (bus_addr == 5'd2) m_en = bus_wdata[NS-1:0];
                for (int s = 0; s < NS; s++)
                    if (int'(bus_addr) == 16 + s) m_route[s] = int'(bus_wdata[11:0]);
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (irq_out !== exp_out) begin
                fails++;
                $display("FAIL R8 cycle compare: irq_out=%h expected=%h", irq_out, exp_out);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input int a, input logic [31:0] e, input string tag);
        bus_addr = 5'(a);
        #1;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic bare_check(input int a, input logic [31:0] e, input string tag);
        bus_addr = 5'(a);
        #1;
        checks++;
        if (bare_rdata !== e) begin
            fails++;
            $display("FAIL %s bare read addr %0d: got %h expected %h", tag, a, bare_rdata, e);
        end
    endtask

    task automatic bit_check(input int c, input int p, input bit e, input string tag);
        checks++;
        if (irq_out[c*NP + p] !== e) begin
            fails++;
            $display("FAIL %s out(cpu %0d, pin %0d): got %b expected %b",
                     tag, c, p, irq_out[c*NP + p], e);
        end
    endtask

    task automatic count_check(input int e, input string tag);
        checks++;
        if ($countones(irq_out) != e) begin
            fails++;
            $display("FAIL %s active outputs: got %0d expected %0d",
                     tag, $countones(irq_out), e);
        end
    endtask

    task automatic raise(input int s);
        src_in[s] = 1'b1;
        step(2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        count_check(0, "R1");
        rd_check(1, 32'h0, "R1");
        rd_check(2, 32'h0, "R1");
        rd_check(3, 32'h0, "R1");

        // R2 capability word
        rd_check(0, 32'h3, "R2");
        bare_check(0, 32'h0, "R2");

        // R3 masking on build without encoded styles, readback on full build
        wr(1, 32'hFFFF_FFFF);
        bare_check(1, 32'h0, "R3");
        rd_check(1, 32'h3, "R3");
        wr(1, 32'h0);
        rd_check(1, 32'h0, "R3");

        // R12 routing word storage
        wr(16, 32'hFFFF_F421);
        rd_check(16, 32'h421, "R12");

        // R4 R5 bitmap decoding: pin2, node1, cpu3 -> cpu 7
        wr(16, 32'h428);
        wr(17, 32'h6CA);   // pin bits 0110 -> 1, node 1100 -> 2, cpu 1010 -> 1 => cpu 9
        wr(18, 32'h011);   // empty pin bitmap -> nowhere
        wr(2, 32'h0F);
        rd_check(2, 32'h0F, "R10");
        raise(0);
        bit_check(7, 2, 1'b1, "R4");
        raise(1);
        bit_check(9, 1, 1'b1, "R4");
        raise(2);
        count_check(2, "R5");
        rd_check(3, 32'h07, "R9");

        // R11 / R6 switch pin field to encoded, routes not rewritten
        wr(1, 32'h1);
        step(1);
        bit_check(7, 4, 1'b1, "R11");
        bit_check(9, 6, 1'b1, "R6");
        bit_check(0, 0, 1'b1, "R11");
        count_check(3, "R11");

        // R7 CPU field encoded: 40, 202, 17 all out of range
        wr(1, 32'h3);
        step(1);
        count_check(0, "R7");
        wr(19, 32'hF0D);
        raise(3);
        bit_check(13, 15, 1'b1, "R7");
        count_check(1, "R7");

        // R10 disable keeps pending
        wr(2, 32'h03);
        step(1);
        bit_check(13, 15, 1'b0, "R10");
        rd_check(3, 32'h0F, "R10");

        // R9 clear with line held high: no re-set
        wr(3, 32'h08);
        rd_check(3, 32'h07, "R9");
        src_in[3] = 1'b0;
        step(1);
        // edge and clear in the same cycle: edge wins
        src_in[3] = 1'b1;
        wr(3, 32'h08);
        rd_check(3, 32'h0F, "R9");
        // plain clear of sources 0..2
        wr(3, 32'h07);
        rd_check(3, 32'h08, "R9");
        wr(2, 32'hFF);
        step(2);
        bit_check(13, 15, 1'b1, "R8");
        count_check(1, "R8");

        // R11 back to bitmap decoding of the same words
        wr(1, 32'h0);
        step(1);
        count_check(0, "R11");

        step(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule